// File: doc/BRIEF.md
# Timing Header Width Converter

This block sits in a parallel video word path in front of a serializer. It takes one word per clock, marked by a valid strobe. The word is either a native 10-bit sample or an 8-bit sample placed in the upper eight bits with the two lowest bits held low. The block emits 10-bit words. An 8-bit stream marks line timing with the header FFh, 00h, 00h, which arrives as 3FCh, 000h, 000h. The receiving end needs 3FFh, 000h, 000h, so the header word must have its two lowest bits raised.

The block cannot recognise the header word when that word arrives. It can only do so after the two zero words that follow it. It therefore holds the two most recent accepted words in a short delay line and releases each word two beats late. A beat is a clock cycle with `valid_i` high. On the beat that brings a second consecutive zero word, the word about to leave has its low bits forced to ones. A one-cycle `trs_start_o` pulse flags that word on the output. A bypass input turns the patch off for native 10-bit streams, which leaves only the two-beat delay.

Cycles with `valid_i` low neither advance nor disturb the delay line. Lookahead therefore spans consecutive beats, not consecutive clocks. Zero runs longer than the header are illegal in the stream format. The block applies the same rule to every window of three beats, so in a run of three zeros the first zero leaves as 003h.

Top module: `trs_sync_widener`

## Requirements
- R1: After reset, and until the first output beat, `valid_o` and `trs_start_o` are 0 and `data_o` is 000h.
- R2: A word that is not patched appears on `data_o` unchanged. It appears in the cycle after the clock edge that accepts the second beat following it.
- R3: The first two beats after reset produce no output. Each later beat produces exactly one cycle with `valid_o` high. Cycles without a beat have `valid_o` low.
- R4: When the next two beats after a word both carry 000h and `bypass_i` is 0 on the second of them, that word leaves with bits [1:0] forced to 11 and bits [9:2] unchanged.
- R5: `trs_start_o` is 1 in exactly the output cycles whose word was patched under R4, and is 0 otherwise.
- R6: If `bypass_i` is 1 on the beat that completes the two-zero lookahead, the word leaves unchanged and `trs_start_o` stays 0.
- R7: The zero test covers all ten bits. A following word with any bit set, such as 001h, 002h, 003h or 200h, prevents the patch.
- R8: The zero words themselves leave unchanged, unless they are followed by two more zeros. In a run of three or more zeros, every zero that has two zeros after it leaves as 003h with a start pulse.
- R9: Idle cycles between beats leave `data_o` stable and do not break the lookahead. Two zero beats separated by idle cycles still trigger the patch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word valid (one beat) |
| data_i | input | 10 | Input word; 8-bit data in bits [9:2] |
| bypass_i | input | 1 | 1 disables the LSB patch |
| valid_o | output | 1 | Output word valid |
| data_o | output | 10 | Delayed, possibly patched word |
| trs_start_o | output | 1 | Marks a patched header word |

## Verification
Two functions can fall in the same cycle. One is the release of a delayed word. The other is the decision to patch that word, which depends on the beat arriving in that very cycle and on `bypass_i` at that moment. The bench provokes this coincidence in several ways. It sends a header for every 8-bit value, toggles bypass exactly on the completing beat, runs all 1024 codes through as data, and sends zero runs of three and four with idle gaps inserted. A reference model kept in the bench holds the last two words it sent. For every output beat, the model computes the expected word and start flag from the incoming word and the bypass level, and the bench compares both against the outputs.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned FIX_W  = 2;
  localparam int unsigned LOOK_N = 2;
endpackage

// File: rtl/trs_zero_det.sv
module trs_zero_det #(
  parameter int unsigned W = trs_pkg::WORD_W
) (
  input  logic [W-1:0] word_i,
  output logic         zero_o
);
  assign zero_o = ~|word_i;
endmodule

// File: rtl/trs_delay_line.sv
module trs_delay_line #(
  parameter int unsigned W     = trs_pkg::WORD_W,
  parameter int unsigned DEPTH = trs_pkg::LOOK_N
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  input  logic [W-1:0]            word_i,
  output logic [DEPTH-1:0][W-1:0] tap_o,
  output logic [DEPTH-1:0]        tap_vld_o
);
  // tap 0 holds the newest word
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] src;
    logic         src_vld;
    if (i == 0) begin : g_head
      assign src     = word_i;
      assign src_vld = 1'b1;
    end else begin : g_body
      assign src     = tap_o[i-1];
      assign src_vld = tap_vld_o[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tap_o[i]     <= '0;
        tap_vld_o[i] <= 1'b0;
      end else if (adv_i) begin
        tap_o[i]     <= src;
        tap_vld_o[i] <= src_vld;
      end
    end
    if (i > 0) begin : g_chk
      assert_fill_order_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        tap_vld_o[i] |-> tap_vld_o[i-1]);
    end
  end
endmodule

// File: rtl/trs_lsb_patch.sv
module trs_lsb_patch #(
  parameter int unsigned W     = trs_pkg::WORD_W,
  parameter int unsigned FIX_W = trs_pkg::FIX_W
) (
  input  logic [W-1:0] word_i,
  input  logic         fix_i,
  output logic [W-1:0] word_o
);
  localparam logic [W-1:0] FIX_MASK = W'((1 << FIX_W) - 1);
  assign word_o = fix_i ? (word_i | FIX_MASK) : word_i;
endmodule

// File: rtl/trs_sync_widener.sv
module trs_sync_widener #(
  parameter int unsigned W      = trs_pkg::WORD_W,
  parameter int unsigned FIX_W  = trs_pkg::FIX_W,
  parameter int unsigned LOOK_N = trs_pkg::LOOK_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  input  logic         bypass_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         trs_start_o
);
  localparam int unsigned OLD = LOOK_N - 1;

  logic [LOOK_N-1:0][W-1:0] tap;
  logic [LOOK_N-1:0]        tap_vld;
  logic [LOOK_N-1:0]        zero;
  logic                     hit;
  logic [W-1:0]             fixed_word;

  trs_delay_line #(.W(W), .DEPTH(LOOK_N)) u_dly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (valid_i),
    .word_i    (data_i),
    .tap_o     (tap),
    .tap_vld_o (tap_vld)
  );

  // lookahead window: incoming word plus all taps newer than the oldest
  for (genvar i = 0; i < LOOK_N; i++) begin : g_zero
    if (i == 0) begin : g_in
      trs_zero_det #(.W(W)) u_zd (.word_i(data_i), .zero_o(zero[i]));
    end else begin : g_tap
      trs_zero_det #(.W(W)) u_zd (.word_i(tap[i-1]), .zero_o(zero[i]));
    end
  end

  assign hit = valid_i & tap_vld[OLD] & (&zero) & ~bypass_i;

  trs_lsb_patch #(.W(W), .FIX_W(FIX_W)) u_fix (
    .word_i (tap[OLD]),
    .fix_i  (hit),
    .word_o (fixed_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      data_o      <= '0;
      trs_start_o <= 1'b0;
    end else begin
      valid_o     <= valid_i & tap_vld[OLD];
      trs_start_o <= hit;
      if (valid_i && tap_vld[OLD]) data_o <= fixed_word;
    end
  end

  assert_start_has_valid_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    trs_start_o |-> valid_o);
  assert_start_lsbs_set_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    trs_start_o |-> (&data_o[FIX_W-1:0]));
  assert_out_needs_beat_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
  assert_bypass_no_start_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bypass_i) |-> !trs_start_o);
  assert_idle_stable_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: tb/trs_sync_widener_bench.sv
module trs_sync_widener_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [9:0] data_i = '0;
  logic       bypass_i = 1'b0;
  logic       valid_o;
  logic [9:0] data_o;
  logic       trs_start_o;

  int n_run = 0;
  int n_fail = 0;
  int n_beat = 0;
  logic [9:0] h1 = '0, h2 = '0, last_out = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trs_sync_widener u_trs_sync_widener (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i),
    .bypass_i(bypass_i), .valid_o(valid_o), .data_o(data_o),
    .trs_start_o(trs_start_o)
  );

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after sampling
  task automatic beat(logic [9:0] w, logic byp);
    logic patch, would;
    logic [9:0] exp_w;
    string tag;
    valid_i = 1'b1; data_i = w; bypass_i = byp;
    @(negedge clk);
    valid_i = 1'b0;
    would = (h1 == 10'h000) && (w == 10'h000);
    patch = would && !byp;
    if (n_beat < 2) begin
      check("R3 priming", int'(valid_o), 0);
      check("R1 quiet start", int'(trs_start_o), 0);
    end else begin
      exp_w = patch ? (h2 | 10'h003) : h2;
      if (patch) tag = "R4";
      else if (would) tag = "R6";
      else if (h2 == 10'h000) tag = "R8";
      else if (h1 == 10'h000 || w < 10'h004 || w == 10'h200) tag = "R7";
      else tag = "R2";
      check("R3 valid", int'(valid_o), 1);
      check(tag, int'(data_o), int'(exp_w));
      check(would ? "R6 start" : "R5 start", int'(trs_start_o), int'(patch));
      last_out = data_o;
    end
    h2 = h1; h1 = w; n_beat++;
  endtask

  task automatic idle();
    valid_i = 1'b0; data_i = 10'h3A5; bypass_i = 1'b0;
    @(negedge clk);
    check("R3 idle", int'(valid_o), 0);
    check("R9 hold", int'(data_o), int'(last_out));
    check("R5 idle", int'(trs_start_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", int'(valid_o), 0);
    check("R1 data", int'(data_o), 0);
    check("R1 start", int'(trs_start_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after", int'(valid_o), 0);

    // 8-bit headers for every value, idle gaps sprinkled (R4, R8, R9)
    for (int v = 0; v < 256; v++) begin
      beat({v[7:0], 2'b00}, 1'b0);
      beat(10'h000, 1'b0);
      if (v % 5 == 0) idle();
      beat(10'h000, 1'b0);
      beat(10'h200 | 10'(v), 1'b0);
      if (v % 7 == 3) idle();
    end
    // every 10-bit code as data, bypass toggling (R2, R7)
    for (int x = 0; x < 1024; x++) beat(10'(x), x[2]);
    // bypass exactly on the completing beat (R6)
    for (int v = 0; v < 256; v++) begin
      beat({v[7:0], 2'b00}, 1'b0);
      beat(10'h000, 1'b0);
      beat(10'h000, v[0]);
      beat(10'h155, 1'b0);
    end
    // near-zero followers (R7)
    for (int k = 1; k < 4; k++) begin
      beat(10'h3FC, 1'b0);
      beat(10'h000, 1'b0);
      beat(10'(k), 1'b0);
      beat(10'h2AA, 1'b0);
    end
    // long zero run with gap (R8, R9)
    beat(10'h3FC, 1'b0);
    for (int z = 0; z < 4; z++) begin
      beat(10'h000, 1'b0);
      idle();
    end
    beat(10'h001, 1'b0);
    beat(10'h002, 1'b0);
    beat(10'h0F0, 1'b0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule